// File: doc/BRIEF.md
# Random Replacement Index Generator

This block chooses which entry of a translation buffer a random-replacement write should overwrite. It holds a 32-bit linear congruential state. Each accepted request advances that state once. The block then reduces the upper half of the new state into the window of replaceable entries. That window starts at the boundary value on `wired_i`, because entries below the boundary are pinned and must never be picked. It ends at the last entry.

The reduction is done by a shift-and-subtract remainder unit. The unit retires one quotient bit per clock, so every result appears a fixed 16 cycles after the request is accepted. The index is registered and qualified by `valid_o`. The index and `valid_o` hold until the next accepted request. A request that arrives while a result is still being computed is dropped.

Top module: `rnd_tlb_index`

## Requirements
- R1: After reset, `valid_o` is 0, `idx_o` is 0 and the internal state is 0, so the first accepted request uses state value 1.
- R2: Each accepted request replaces the state S with (S × 314159 + 1) truncated to 32 bits.
- R3: When `wired_i` (sampled at acceptance) is below ENTRIES, the index equals ((S >> 16) mod (ENTRIES − wired)) + wired, where S is the updated state and S >> 16 is bits 31:16.
- R4: With the sampled boundary below ENTRIES, every valid index lies in [wired, ENTRIES − 1].
- R5: When the sampled boundary is ENTRIES or more, the index is ENTRIES − 1.
- R6: `valid_o` falls in the cycle after acceptance and rises exactly 16 clock edges after the accepting edge.
- R7: A request asserted while a computation is in progress is ignored: the state advances only once per accepted request.
- R8: While no request is accepted, `valid_o` and `idx_o` hold their values.
- R9: `wired_i` is sampled only at acceptance; changing it during the computation does not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Request strobe; accepted when no computation is running |
| wired_i | input | IDX_W+1 | Boundary below which entries are pinned |
| idx_o | output | IDX_W | Chosen entry index |
| valid_o | output | 1 | Index is ready and held |

## Verification
The assertions assume that `req_i` and `wired_i` are settled at every rising edge. They also assume that reset is held for at least one edge before any request, so the latency counter in the checker starts from a known point. The bench changes inputs only at falling edges and holds reset for several cycles. During computations it deliberately toggles `req_i` and changes `wired_i`. This tests R7 and R9 against a reference model that advances its state once per accepted request.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  localparam int SEED_W    = 32;
  localparam int IDX_SHIFT = 16;
  localparam int Q_W       = SEED_W - IDX_SHIFT;
  localparam logic [SEED_W-1:0] LCG_MUL = 32'd314159;
  localparam logic [SEED_W-1:0] LCG_INC = 32'd1;

  // One step of the linear congruential generator, modulo 2^SEED_W.
  function automatic logic [SEED_W-1:0] lcg_next(input logic [SEED_W-1:0] s);
    return s * LCG_MUL + LCG_INC;
  endfunction

  // The bits that feed the reduction.
  function automatic logic [Q_W-1:0] lcg_upper(input logic [SEED_W-1:0] s);
    return s[SEED_W-1:IDX_SHIFT];
  endfunction
endpackage

// File: rtl/rnd_lcg_reg.sv
module rnd_lcg_reg
  import rnd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              advance_i,
  output logic [SEED_W-1:0] seed_o,
  output logic [SEED_W-1:0] next_o
);
  assign next_o = lcg_next(seed_o);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)        seed_o <= '0;
    else if (advance_i) seed_o <= next_o;
  end
endmodule

// File: rtl/rnd_mod_unit.sv
module rnd_mod_unit #(
  parameter int Q_W   = 16,
  parameter int DIV_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [Q_W-1:0]   dvd_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             done_o,
  output logic [DIV_W-1:0] rem_o
);
  localparam int RW = DIV_W + 1;
  localparam int CW = $clog2(Q_W) + 1;

  logic             run_q;
  logic [CW-1:0]    cnt_q;
  logic [Q_W-1:0]   shf_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] rem_q;
  logic [DIV_W-1:0] rem_nx;
  logic             last_w;

  // Restoring remainder step: bring in one dividend bit, subtract if it fits.
  function automatic logic [DIV_W-1:0] rem_step(input logic [DIV_W-1:0] r,
                                                input logic b,
                                                input logic [DIV_W-1:0] d);
    logic [RW-1:0] t;
    t = {r, b};
    if (t >= {1'b0, d}) t = t - {1'b0, d};
    return t[DIV_W-1:0];
  endfunction

  assign rem_nx = rem_step(rem_q, shf_q[Q_W-1], div_q);
  assign last_w = (cnt_q == CW'(Q_W - 1));
  assign done_o = run_q && last_w;
  assign rem_o  = rem_nx;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      shf_q <= '0;
      div_q <= '0;
      rem_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
      shf_q <= dvd_i;
      div_q <= div_i;
      rem_q <= '0;
    end else if (run_q) begin
      rem_q <= rem_nx;
      shf_q <= shf_q << 1;
      cnt_q <= cnt_q + CW'(1);
      if (last_w) run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rnd_tlb_index.sv
module rnd_tlb_index #(
  parameter  int ENTRIES = 16,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int WIRED_W = IDX_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [WIRED_W-1:0] wired_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               valid_o
);
  import rnd_pkg::*;

  logic               busy_q;
  logic               accept_w;
  logic               done_w;
  logic [SEED_W-1:0]  seed_q;
  logic [SEED_W-1:0]  seed_nx;
  logic               clamp_w;
  logic               clamp_q;
  logic [WIRED_W-1:0] div_w;
  logic [WIRED_W-1:0] wired_q;
  logic [WIRED_W-1:0] rem_w;

  // Place the remainder above the pinned entries, or saturate to the top.
  function automatic logic [IDX_W-1:0] place(input logic [WIRED_W-1:0] rem,
                                             input logic [WIRED_W-1:0] base,
                                             input logic clamp);
    logic [WIRED_W-1:0] sum;
    sum = rem + base;
    if (clamp) return IDX_W'(ENTRIES - 1);
    return sum[IDX_W-1:0];
  endfunction

  assign accept_w = req_i && !busy_q;
  assign clamp_w  = (wired_i >= WIRED_W'(ENTRIES));
  assign div_w    = clamp_w ? WIRED_W'(1) : (WIRED_W'(ENTRIES) - wired_i);

  rnd_lcg_reg u_lcg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .advance_i(accept_w),
    .seed_o   (seed_q),
    .next_o   (seed_nx)
  );

  rnd_mod_unit #(.Q_W(Q_W), .DIV_W(WIRED_W)) u_mod (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(accept_w),
    .dvd_i  (lcg_upper(seed_nx)),
    .div_i  (div_w),
    .done_o (done_w),
    .rem_o  (rem_w)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      valid_o <= 1'b0;
      idx_o   <= '0;
      wired_q <= '0;
      clamp_q <= 1'b0;
    end else if (accept_w) begin
      busy_q  <= 1'b1;
      valid_o <= 1'b0;
      wired_q <= wired_i;
      clamp_q <= clamp_w;
    end else if (done_w) begin
      busy_q  <= 1'b0;
      valid_o <= 1'b1;
      idx_o   <= place(rem_w, wired_q, clamp_q);
    end
  end
endmodule

// File: rtl/rnd_tlb_index_chk.sv
module rnd_tlb_index_chk #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int WIRED_W = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               accept_w,
  input logic               busy_q,
  input logic               done_w,
  input logic               valid_o,
  input logic               clamp_q,
  input logic [IDX_W-1:0]   idx_o,
  input logic [WIRED_W-1:0] wired_q,
  input logic [31:0]        seed_q
);
  localparam int QB = 16;
  localparam int LW = $clog2(QB) + 1;

  logic [LW-1:0] lat_cnt;
  always_ff @(posedge clk_i) begin
    if (!rst_ni)       lat_cnt <= '0;
    else if (accept_w) lat_cnt <= '0;
    else if (busy_q)   lat_cnt <= lat_cnt + LW'(1);
  end

  a_r2_seed_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_w |=> seed_q == $past(seed_q) * 32'd314159 + 32'd1);

  a_r7_seed_still: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(seed_q));

  a_r6_clear_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_w |=> !valid_o && busy_q);

  a_r6_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (done_w == (lat_cnt == LW'(QB - 1))));

  a_r6_done_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_w |=> valid_o);

  a_r4_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !clamp_q) |-> ({1'b0, idx_o} >= wired_q));

  a_r5_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && clamp_q) |-> (idx_o == IDX_W'(ENTRIES - 1)));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !accept_w) |=> (valid_o && $stable(idx_o)));
endmodule

bind rnd_tlb_index rnd_tlb_index_chk #(
  .ENTRIES(ENTRIES), .IDX_W(IDX_W), .WIRED_W(WIRED_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .accept_w(accept_w),
  .busy_q  (busy_q),
  .done_w  (done_w),
  .valid_o (valid_o),
  .clamp_q (clamp_q),
  .idx_o   (idx_o),
  .wired_q (wired_q),
  .seed_q  (seed_q)
);

// File: tb/test_rnd_tlb_index.sv
module test_rnd_tlb_index;
  localparam int ENT = 16;
  localparam int NV  = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [4:0] wired = '0;
  logic [3:0] idx;
  logic       valid;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] mseed = '0;

  always #4 clk = ~clk;

  rnd_tlb_index #(.ENTRIES(ENT)) i_rnd_tlb_index (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req),
    .wired_i(wired), .idx_o(idx), .valid_o(valid)
  );

  // Vector: {noise during computation, boundary value}
  localparam logic [5:0] VEC [NV] = '{
    {1'b0, 5'd0},  {1'b0, 5'd3},  {1'b1, 5'd15}, {1'b0, 5'd16},
    {1'b1, 5'd31}, {1'b0, 5'd8},  {1'b1, 5'd0},  {1'b0, 5'd14},
    {1'b1, 5'd1},  {1'b1, 5'd5},  {1'b0, 5'd0},  {1'b0, 5'd10}
  };

  function automatic int model_idx(input logic [31:0] s, input int w);
    if (w >= ENT) return ENT - 1;
    return int'(s >> 16) % (ENT - w) + w;
  endfunction

  task automatic check(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // Issue one request; optional noise pulses req and alters wired while busy.
  task automatic one_req(input int w, input bit noise);
    int e;
    @(negedge clk);
    req = 1'b1;
    wired = 5'(w);
    @(negedge clk);
    req = 1'b0;
    mseed = mseed * 32'd314159 + 32'd1;
    check("R6 valid low after accept", int'(valid), 0);
    for (int i = 1; i < 16; i++) begin
      @(negedge clk);
      if (noise) begin
        req = (i % 2 == 1);
        wired = 5'(i);
      end
    end
    req = 1'b0;
    check("R6 still busy at edge 15", int'(valid), 0);
    @(negedge clk);
    check("R6 valid at edge 16", int'(valid), 1);
    e = model_idx(mseed, w);
    if (noise) check("R7/R9 index unaffected by noise", int'(idx), e);
    else if (w >= ENT) check("R5 clamp index", int'(idx), e);
    else check("R3 index value", int'(idx), e);
    if (w < ENT) check("R4 index in window", int'(int'(idx) >= w && int'(idx) < ENT), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int held;
    repeat (4) @(negedge clk);
    check("R1 valid after reset", int'(valid), 0);
    check("R1 index after reset", int'(idx), 0);
    rst_n = 1'b1;

    // First state value is 1, upper bits 0: index equals the boundary.
    one_req(3, 1'b0);
    check("R1 first index from zero state", int'(idx), 3);
    check("R2 model state after first step", int'(mseed), 1);

    for (int v = 0; v < NV; v++) one_req(int'(VEC[v][4:0]), VEC[v][5]);

    // R8: nothing accepted, outputs hold.
    held = int'(idx);
    req = 1'b0;
    repeat (5) @(negedge clk);
    check("R8 valid held", int'(valid), 1);
    check("R8 index held", int'(idx), held);

    // Reset during a computation, then restart from zero state (R1).
    @(negedge clk);
    req = 1'b1;
    wired = 5'd2;
    @(negedge clk);
    req = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 valid cleared by reset", int'(valid), 0);
    check("R1 index cleared by reset", int'(idx), 0);
    rst_n = 1'b1;
    mseed = '0;
    one_req(0, 1'b0);
    check("R1 restart index", int'(idx), 0);
    one_req(0, 1'b0);
    check("R2 second state index", int'(idx), int'(32'd314160 >> 16) % 16);

    summary();
    $finish;
  end
endmodule